// File: doc/BRIEF.md
# Dual-channel serial DAC write sequencer

This block connects a small host, such as a soft processor, to a two-channel 8-bit serial DAC. The host stores a left sample and a right sample in two holding registers, each through its own write enable, and then pulses a start strobe. The block then sends two 16-bit frames back to back on a three-wire serial link: first the left frame, then the right frame. Each frame is an 8-bit configuration byte followed by the sample, shifted most significant bit first.

The serial clock runs at half the system clock. Serial data changes only while the serial clock is low, so it is stable at the DAC's rising sampling edge. An active-low frame select wraps each frame and goes high again between the two frames. A ready flag stays low for the whole 68-cycle transfer, and a one-cycle done pulse marks its end so that it can be used as an interrupt.

A fixed nine-state controller, a 4-bit bit counter and a 16-bit output shift register do the work. The design has no general serial-master options.

Top module: `dac_pair_writer`

## Requirements
- R1: The left sample register loads `left_in` on a rising clock edge only while `left_we` is high, and the right register loads `right_in` only while `right_we` is high. Bus changes while the enable is low have no effect on the frames that are sent.
- R2: `start` sampled high while `ready` is 1 begins a transfer, and `ready` is 0 in the next cycle. `start` sampled while a transfer is running is ignored and does not cause a second transfer.
- R3: `ready` stays low for exactly 68 consecutive clock cycles for each transfer.
- R4: `done` is high for exactly one cycle: the first cycle in which `ready` is 1 again after a transfer. It is low at all other times.
- R5: `sclk` runs at half the clock rate. Each high phase lasts one cycle and follows a low cycle. Each frame has 16 high phases, and `sclk` is low while the block is idle.
- R6: `frame_n` is high while the block is idle. It is low whenever `sclk` is high. Between the left frame and the right frame it is high for exactly two cycles.
- R7: Every transfer sends the left frame first and the right frame second. Each frame is 16 bits, most significant bit first: the configuration byte in bits 15:8 and the sample in bits 7:0.
- R8: Configuration byte layout: bit 7 = 1 (internal reference), bits 6:5 = 11 (both channels powered), bits 4:3 = 01 (output updates directly from shifted data), bit 2 = channel address (0 left, 1 right), bits 1:0 = 00. This gives 0xE8 for the left frame and 0xEC for the right frame.
- R9: `sdata` does not change in a cycle in which `sclk` is high.
- R10: While reset is asserted and right after it, `ready`=1, `done`=0, `sclk`=0 and `frame_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high asynchronous reset |
| start | input | 1 | Start strobe for a two-frame transfer |
| left_we | input | 1 | Write enable of the left sample register |
| right_we | input | 1 | Write enable of the right sample register |
| left_in | input | 8 | Left sample bus |
| right_in | input | 8 | Right sample bus |
| ready | output | 1 | 1 when idle, 0 during a transfer |
| done | output | 1 | One-cycle pulse when a transfer ends |
| sclk | output | 1 | Serial clock to the DAC |
| sdata | output | 1 | Serial data to the DAC |
| frame_n | output | 1 | Active-low frame select |

## Verification
The hardest situation to reach from the ports is a start strobe that arrives in the middle of a transfer. If the block accepted it, the result would be a second pair of frames long after the first, or the first transfer would be cut short. The stimulus pulses `start` deep inside the left frame. The scoreboard then confirms three things: exactly two frames arrive, the busy window is still 68 cycles, and no further frame appears over a long idle stretch. A second case drives new values on both sample buses with the write enables low just before a start. This shows that the frames carry the values that were latched earlier.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    localparam int SAMPLE_W    = 8;
    localparam int CFG_W       = 8;
    localparam int FRAME_W     = CFG_W + SAMPLE_W;
    localparam int BITCNT_W    = $clog2(FRAME_W);
    localparam int SHIFT_CYC   = 2 * FRAME_W;
    localparam int XFER_CYCLES = 2 * (SHIFT_CYC + 1) + 2;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_LOAD_L  = 4'd1,
        S_LOW_L   = 4'd2,
        S_HIGH_L  = 4'd3,
        S_GAP     = 4'd4,
        S_LOAD_R  = 4'd5,
        S_LOW_R   = 4'd6,
        S_HIGH_R  = 4'd7,
        S_FINAL   = 4'd8
    } seq_state_e;

    typedef struct packed {
        logic  osr_load;
        logic  osr_shift;
        logic  cnt_en;
        chan_e sel;
        logic  sclk;
        logic  frame_n;
    } seq_ctl_t;

    // Configuration byte: [7] internal ref, [6:5] both channels on,
    // [4:3] direct update mode, [2] channel address, [1:0] zero.
    function automatic logic [CFG_W-1:0] cfg_byte(chan_e ch);
        logic [CFG_W-1:0] b;
        b      = '0;
        b[7]   = 1'b1;
        b[6:5] = 2'b11;
        b[4:3] = 2'b01;
        b[2]   = (ch == CH_RIGHT);
        return b;
    endfunction

    function automatic seq_ctl_t decode(seq_state_e st);
        seq_ctl_t c;
        c = '{osr_load: 1'b0, osr_shift: 1'b0, cnt_en: 1'b0,
              sel: CH_LEFT, sclk: 1'b0, frame_n: 1'b1};
        unique case (st)
            S_LOAD_L: begin c.osr_load = 1'b1; c.sel = CH_LEFT;  end
            S_LOW_L:  begin c.cnt_en = 1'b1; c.frame_n = 1'b0; end
            S_HIGH_L: begin c.osr_shift = 1'b1; c.sclk = 1'b1; c.frame_n = 1'b0; end
            S_LOAD_R: begin c.osr_load = 1'b1; c.sel = CH_RIGHT; end
            S_LOW_R:  begin c.cnt_en = 1'b1; c.frame_n = 1'b0; c.sel = CH_RIGHT; end
            S_HIGH_R: begin c.osr_shift = 1'b1; c.sclk = 1'b1; c.frame_n = 1'b0;
                            c.sel = CH_RIGHT; end
            S_FINAL:  begin c.frame_n = 1'b0; end
            default:  begin end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dac_sample_bank.sv
module dac_sample_bank
    import dac_seq_pkg::*;
#(
    parameter int W = SAMPLE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         left_we,
    input  logic         right_we,
    input  logic [W-1:0] left_in,
    input  logic [W-1:0] right_in,
    input  chan_e        sel,
    output logic [W-1:0] sample
);

    logic [W-1:0] hold [2];
    logic [1:0]   we;
    logic [W-1:0] din [2];

    assign we[0]  = left_we;
    assign we[1]  = right_we;
    assign din[0] = left_in;
    assign din[1] = right_in;

    for (genvar i = 0; i < 2; i++) begin : g_reg
        always_ff @(posedge clk or posedge rst) begin
            if (rst)        hold[i] <= '0;
            else if (we[i]) hold[i] <= din[i];
        end
    end

    assign sample = (sel == CH_RIGHT) ? hold[1] : hold[0];

endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter
    import dac_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                shift,
    input  chan_e               sel,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                sdata
);

    logic [FRAME_W-1:0] osr;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)        osr <= '0;
        else if (load)  osr <= {cfg_byte(sel), sample};
        else if (shift) osr <= {osr[FRAME_W-2:0], 1'b0};
    end

    assign sdata = osr[FRAME_W-1];

endmodule

// File: rtl/dac_bit_counter.sv
module dac_bit_counter
    import dac_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic wrapped
);

    localparam logic [BITCNT_W-1:0] LAST = BITCNT_W'(FRAME_W - 1);

    logic [BITCNT_W-1:0] cnt;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (en)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign wrapped = (cnt == '0);

endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
    import dac_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     frame_end,
    output seq_ctl_t ctl,
    output logic     ready,
    output logic     done
);

    seq_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (start) st_nx = S_LOAD_L;
            S_LOAD_L: st_nx = S_LOW_L;
            S_LOW_L:  st_nx = S_HIGH_L;
            S_HIGH_L: st_nx = frame_end ? S_GAP : S_LOW_L;
            S_GAP:    st_nx = S_LOAD_R;
            S_LOAD_R: st_nx = S_LOW_R;
            S_LOW_R:  st_nx = S_HIGH_R;
            S_HIGH_R: st_nx = frame_end ? S_FINAL : S_LOW_R;
            S_FINAL:  st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st   <= S_IDLE;
            done <= 1'b0;
        end else begin
            st   <= st_nx;
            done <= (st == S_FINAL);
        end
    end

    assign ctl   = decode(st);
    assign ready = (st == S_IDLE);

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && ready) |=> !ready);  // R2

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ready && st != S_FINAL) |=> !ready);  // R2

    AST_SCLK_HALF: assert property (@(posedge clk) disable iff (rst)
        ctl.sclk |=> !ctl.sclk);  // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R4

endmodule

// File: rtl/dac_pair_writer.sv
module dac_pair_writer
    import dac_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       left_we,
    input  logic       right_we,
    input  logic [7:0] left_in,
    input  logic [7:0] right_in,
    output logic       ready,
    output logic       done,
    output logic       sclk,
    output logic       sdata,
    output logic       frame_n
);

    seq_ctl_t            ctl;
    logic                frame_end;
    logic [SAMPLE_W-1:0] sample;

    dac_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .frame_end (frame_end),
        .ctl       (ctl),
        .ready     (ready),
        .done      (done)
    );

    dac_sample_bank #(.W(SAMPLE_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .left_we  (left_we),
        .right_we (right_we),
        .left_in  (left_in),
        .right_in (right_in),
        .sel      (ctl.sel),
        .sample   (sample)
    );

    dac_bit_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.osr_load),
        .en      (ctl.cnt_en),
        .wrapped (frame_end)
    );

    dac_frame_shifter u_osr (
        .clk    (clk),
        .rst    (rst),
        .load   (ctl.osr_load),
        .shift  (ctl.osr_shift),
        .sel    (ctl.sel),
        .sample (sample),
        .sdata  (sdata)
    );

    assign sclk    = ctl.sclk;
    assign frame_n = ctl.frame_n;

    // Busy-window watch: counts cycles with ready low.
    logic [$clog2(XFER_CYCLES+2)-1:0] busy_cnt;
    always_ff @(posedge clk or posedge rst) begin
        if (rst)        busy_cnt <= '0;
        else if (ready) busy_cnt <= '0;
        else            busy_cnt <= busy_cnt + 1'b1;
    end

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
        (!ready && busy_cnt == ($bits(busy_cnt))'(XFER_CYCLES - 1)) |=> ready);  // R3

    AST_SDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sdata));  // R9

    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !frame_n);  // R6

    AST_DONE_AT_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);  // R4

endmodule

// File: tb/tb_dac_pair_writer.sv
module tb_dac_pair_writer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       left_we = 1'b0;
    logic       right_we = 1'b0;
    logic [7:0] left_in = '0;
    logic [7:0] right_in = '0;
    logic       ready, done, sclk, sdata, frame_n;

    always #2 clk = ~clk;

    dac_pair_writer dut (
        .clk(clk), .rst(rst), .start(start),
        .left_we(left_we), .right_we(right_we),
        .left_in(left_in), .right_in(right_in),
        .ready(ready), .done(done), .sclk(sclk),
        .sdata(sdata), .frame_n(frame_n)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int frames_seen = 0;
    int frames_sent = 0;
    logic [15:0] exp_q [$];

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Driver side: expected frames are pushed, R8 byte values from the spec.
    task automatic push_pair(input logic [7:0] l, input logic [7:0] r);
        exp_q.push_back({8'hE8, l});
        exp_q.push_back({8'hEC, r});
        frames_sent += 2;
    endtask

    task automatic write_samples(input logic [7:0] l, input logic [7:0] r);
        @(negedge clk);
        left_in = l; right_in = r; left_we = 1'b1; right_we = 1'b1;
        @(negedge clk);
        left_we = 1'b0; right_we = 1'b0;
    endtask

    task automatic pulse_start;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle;
        @(negedge clk);
        while (!ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_pair(input logic [7:0] l, input logic [7:0] r);
        write_samples(l, r);
        push_pair(l, r);
        pulse_start();
        chk(ready == 1'b0, "R2", "ready after start", int'(ready), 0);
        wait_idle();
    endtask

    // Monitor: rebuild frames and watch timing.
    logic [15:0] shb = '0;
    int   nbits = 0;
    int   busy_n = 0;
    int   hi_run = 0;
    int   frames_in_xfer = 0;
    logic chk_done_low = 1'b0;
    logic prev_sdata = 1'b0;
    logic prev_sclk = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk) begin
                chk(prev_sclk == 1'b0, "R5", "sclk high two cycles", 1, 0);
                chk(sdata == prev_sdata, "R9", "sdata moved in sclk high", int'(sdata), int'(prev_sdata));
                if (frame_n) chk(1'b0, "R6", "sclk high with frame_n high", 1, 0);
                shb = {shb[14:0], sdata};
                nbits++;
                if (nbits == 16) begin
                    nbits = 0;
                    frames_seen++;
                    frames_in_xfer++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2", "unexpected frame", int'(shb), 0);
                    end else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        chk(shb[15:8] == e[15:8], "R8", "config byte", int'(shb[15:8]), int'(e[15:8]));
                        chk(shb == e, "R7", "frame", int'(shb), int'(e));
                    end
                end
            end
            if (frame_n && nbits != 0)
                chk(1'b0, "R6", "frame_n high mid-frame", nbits, 0);

            if (!ready) begin
                busy_n++;
                if (frame_n) hi_run++;
                else begin
                    if (hi_run > 0 && frames_in_xfer == 1)
                        chk(hi_run == 2, "R6", "inter-frame gap", hi_run, 2);
                    hi_run = 0;
                end
                if (done) chk(1'b0, "R4", "done while busy", 1, 0);
            end else begin
                if (busy_n > 0) begin
                    chk(busy_n == 68, "R3", "busy length", busy_n, 68);
                    chk(done == 1'b1, "R4", "done at ready return", int'(done), 1);
                    chk(frames_in_xfer == 2, "R7", "frames per transfer", frames_in_xfer, 2);
                    chk_done_low = 1'b1;
                end else if (chk_done_low) begin
                    chk(done == 1'b0, "R4", "done width", int'(done), 0);
                    chk_done_low = 1'b0;
                end else if (done) begin
                    chk(1'b0, "R4", "stray done", 1, 0);
                end
                if (sclk) chk(1'b0, "R5", "sclk high while idle", 1, 0);
                if (!frame_n) chk(1'b0, "R6", "frame_n low while idle", 0, 1);
                busy_n = 0;
                hi_run = 0;
                frames_in_xfer = 0;
            end
            prev_sdata = sdata;
            prev_sclk  = sclk;
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 during reset
        chk(ready == 1'b1, "R10", "ready in reset", int'(ready), 1);
        chk(done == 1'b0, "R10", "done in reset", int'(done), 0);
        chk(sclk == 1'b0, "R10", "sclk in reset", int'(sclk), 0);
        chk(frame_n == 1'b1, "R10", "frame_n in reset", int'(frame_n), 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(ready == 1'b1 && done == 1'b0 && sclk == 1'b0 && frame_n == 1'b1,
            "R10", "state after reset", {ready, done, sclk, frame_n}, 4'b1001);

        send_pair(8'h00, 8'hFF);
        send_pair(8'hA5, 8'h5A);
        send_pair(8'h80, 8'h01);
        send_pair(8'hFF, 8'h00);

        // R1: bus changes with enables low must not reach the frames
        write_samples(8'h11, 8'h22);
        @(negedge clk);
        left_in = 8'h99; right_in = 8'h77;
        push_pair(8'h11, 8'h22);
        pulse_start();
        chk(ready == 1'b0, "R1", "transfer started", int'(ready), 0);
        repeat (10) @(negedge clk);
        left_in = 8'h3C; right_in = 8'hC3;
        wait_idle();

        // R2: start pulse deep inside a transfer is ignored
        write_samples(8'h69, 8'h96);
        push_pair(8'h69, 8'h96);
        pulse_start();
        repeat (20) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (150) @(negedge clk);
        chk(ready == 1'b1, "R2", "no second transfer", int'(ready), 1);
        chk(frames_seen == frames_sent, "R2", "frame count", frames_seen, frames_sent);
        chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

        finish_run();
    end

endmodule